// File: doc/BRIEF.md
# Banked Memory Expansion Window Mapper

This block widens a 16-bit CPU address into a 19-bit physical address through two bank-switching windows. Each window has a start register, a bank register and a 2-bit size code. When the CPU address falls inside an enabled window, the low address bits pass through as the offset inside the window. The bank number then fills the expansion lines above that offset, up to the top expansion line (line 18). When no window matches, the three expansion lines that overlap CPU address bits 15..13 carry those CPU bits, and the three highest lines are driven low.

The expansion lines share six port pins with general-purpose I/O. A pin-assignment register selects, pin by pin, which pins carry expansion lines. A pin that is assigned to an overlapping line which neither window uses therefore still shows the raw CPU address bit. A mapping-size register holds both window sizes and two source bits. The source bits tell the two general-purpose chip-select decoders whether to compare against the 64 KB CPU address or against the expanded address.

All registers sit on a simple single-cycle register bus. Writes take effect at the clock edge, and reads are combinational. The address path is purely combinational and has no flow control. It follows `cpu_addr` in the same cycle.

Top module: `bank_window_mapper`

## Requirements
- R1: After reset, every register reads 0x00, `pin_is_xa` is 0, both chip-select source outputs are 0, no window is active, and `xa` equals {000, cpu_addr[15:13]}.
- R2: Register address 0 is the pin-assignment register. Bits [5:0] are stored and drive `pin_is_xa[5:0]`, where bit i set means the pin carries expansion line 13+i. Bits [7:6] always read 0.
- R3: Register address 1 is the mapping-size register, laid out as {cs2 source, cs1 source, window-2 size[1:0], 2'b00, window-1 size[1:0]}. Bits [3:2] always read 0. `cs2_use_xa` follows bit 7 and `cs1_use_xa` follows bit 6.
- R4: Addresses 2 and 4 hold the 8-bit start byte of windows 1 and 2. Addresses 3 and 5 hold their 6-bit bank numbers, whose bits [7:6] read 0. A window with size code 00 never matches. Codes 01 and 10 match from start_byte×256 through start_byte×256 + 8 KB − 1 and + 16 KB − 1 respectively. Code 11 matches 0x4000–0xBFFF and ignores the start byte. `win_active` is 01 for window 1 and 10 for window 2.
- R5: With an 8 KB window (code 01) selected, `xa[5:0]` equals bank[5:0].
- R6: With a 16 KB window (code 10) selected, `xa[0]` equals cpu_addr[13] and `xa[5:1]` equals bank[4:0].
- R7: With the 32 KB window at 0x4000 (code 11) selected, `xa[0]` equals cpu_addr[13] and `xa[5:1]` equals bank[4:0].
- R8: When both windows match, window 1 is selected.
- R9: When no window matches, `xa[2:0]` equals cpu_addr[15:13] and `xa[5:3]` is 0.
- R10: `phys_addr` equals {xa, cpu_addr[12:0]} at all times.
- R11: Register addresses 6 and 7 read 0x00. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cpu_addr | input | 16 | CPU address |
| xa | output | 6 | Expansion lines 13..18 (bit 0 is line 13) |
| phys_addr | output | 19 | Expanded physical address |
| pin_is_xa | output | 6 | Per-pin expansion assignment |
| win_active | output | 2 | Selected window, one-hot or zero |
| cs1_use_xa | output | 1 | Chip select 1 decodes the expanded address |
| cs2_use_xa | output | 1 | Chip select 2 decodes the expanded address |

## Verification
The bench builds the block with its default parameters: a 16-bit CPU address, expansion lines starting at 13, and six expansion lines. Three of those lines overlap the CPU address, so the fall-back path to raw CPU bits is exercised. The bench sweeps all sixteen pairs of size codes while the CPU address steps through the full 64 KB space. This reaches window edges, overlapping windows that test priority, and the fixed 32 KB placement. A bank value of 0x2A exposes which bank bits are dropped by the shift used for the 16 KB and 32 KB windows.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam int CPU_AW = 16;
  localparam int XA_LO  = 13;
  localparam int XA_N   = 6;
  localparam int OVL    = CPU_AW - XA_LO;
  localparam int PA_W   = XA_LO + XA_N;
  localparam int REG_DW = 8;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_PIN   = 3'd0;
  localparam logic [REG_AW-1:0] RA_SIZE  = 3'd1;
  localparam logic [REG_AW-1:0] RA_W1BAS = 3'd2;
  localparam logic [REG_AW-1:0] RA_W1BNK = 3'd3;
  localparam logic [REG_AW-1:0] RA_W2BAS = 3'd4;
  localparam logic [REG_AW-1:0] RA_W2BNK = 3'd5;

  typedef enum logic [1:0] {
    WSZ_OFF = 2'b00,
    WSZ_8K  = 2'b01,
    WSZ_16K = 2'b10,
    WSZ_32K = 2'b11
  } wsz_e;

  typedef struct packed {
    logic [REG_DW-1:0] base;
    logic [XA_N-1:0]   bank;
    wsz_e              size;
  } win_cfg_t;
endpackage

// File: rtl/bwm_regs.sv
module bwm_regs
  import bwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic [XA_N-1:0]   pin_assign,
  output logic [1:0]        cs_src,
  output win_cfg_t          cfg_w1,
  output win_cfg_t          cfg_w2
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_assign <= '0;
      cs_src     <= '0;
      cfg_w1     <= '0;
      cfg_w2     <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_PIN:   pin_assign <= reg_wdata[XA_N-1:0];
        RA_SIZE: begin
          cs_src      <= reg_wdata[7:6];
          cfg_w2.size <= wsz_e'(reg_wdata[5:4]);
          cfg_w1.size <= wsz_e'(reg_wdata[1:0]);
        end
        RA_W1BAS: cfg_w1.base <= reg_wdata;
        RA_W1BNK: cfg_w1.bank <= reg_wdata[XA_N-1:0];
        RA_W2BAS: cfg_w2.base <= reg_wdata;
        RA_W2BNK: cfg_w2.bank <= reg_wdata[XA_N-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_PIN:   reg_rdata[XA_N-1:0] = pin_assign;
      RA_SIZE:  reg_rdata = {cs_src, cfg_w2.size, 2'b00, cfg_w1.size};
      RA_W1BAS: reg_rdata = cfg_w1.base;
      RA_W1BNK: reg_rdata[XA_N-1:0] = cfg_w1.bank;
      RA_W2BAS: reg_rdata = cfg_w2.base;
      RA_W2BNK: reg_rdata[XA_N-1:0] = cfg_w2.bank;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bwm_window.sv
module bwm_window
  import bwm_pkg::*;
(
  input  logic [CPU_AW-1:0] cpu_addr,
  input  win_cfg_t          cfg,
  output logic              hit,
  output logic [XA_N-1:0]   xa_win
);
  localparam logic [CPU_AW:0] FIX_BASE = 17'h04000;

  logic [CPU_AW:0] start, span, last;
  logic [1:0]      shamt;
  logic [XA_N-1:0] hi_mask, bank_sh, cpu_hi;

  always_comb begin
    start = {1'b0, cfg.base, 8'h00};
    span  = 17'h02000;
    shamt = 2'd0;
    case (cfg.size)
      WSZ_8K:  begin span = 17'h02000; shamt = 2'd0; end
      WSZ_16K: begin span = 17'h04000; shamt = 2'd1; end
      WSZ_32K: begin span = 17'h08000; shamt = 2'd1; start = FIX_BASE; end
      default: ;
    endcase
    last = start + span - 17'd1;
    hit  = (cfg.size != WSZ_OFF) && ({1'b0, cpu_addr} >= start)
           && ({1'b0, cpu_addr} <= last);
  end

  assign hi_mask = {XA_N{1'b1}} << shamt;
  assign bank_sh = cfg.bank << shamt;
  assign cpu_hi  = {{(XA_N-OVL){1'b0}}, cpu_addr[CPU_AW-1:XA_LO]};
  assign xa_win  = (bank_sh & hi_mask) | (cpu_hi & ~hi_mask);
endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
  import bwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic [XA_N-1:0]   xa,
  output logic [PA_W-1:0]   phys_addr,
  output logic [XA_N-1:0]   pin_is_xa,
  output logic [1:0]        win_active,
  output logic              cs1_use_xa,
  output logic              cs2_use_xa
);
  localparam int NWIN = 2;

  win_cfg_t        cfg_w1, cfg_w2;
  win_cfg_t        cfg   [NWIN];
  logic [NWIN-1:0] hit;
  logic [XA_N-1:0] xa_w  [NWIN];
  logic [1:0]      cs_src;

  bwm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_assign(pin_is_xa),
    .cs_src(cs_src), .cfg_w1(cfg_w1), .cfg_w2(cfg_w2)
  );

  assign cfg[0] = cfg_w1;
  assign cfg[1] = cfg_w2;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    bwm_window u_win (
      .cpu_addr(cpu_addr), .cfg(cfg[w]), .hit(hit[w]), .xa_win(xa_w[w])
    );
  end

  always_comb begin
    win_active = 2'b00;
    xa = {{(XA_N-OVL){1'b0}}, cpu_addr[CPU_AW-1:XA_LO]};
    if (hit[0]) begin
      win_active = 2'b01;
      xa = xa_w[0];
    end else if (hit[1]) begin
      win_active = 2'b10;
      xa = xa_w[1];
    end
  end

  assign phys_addr  = {xa, cpu_addr[XA_LO-1:0]};
  assign cs1_use_xa = cs_src[0];
  assign cs2_use_xa = cs_src[1];
endmodule

// File: rtl/bwm_checker.sv
module bwm_checker
  import bwm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [REG_DW-1:0] reg_wdata,
  input logic [REG_DW-1:0] reg_rdata,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic [XA_N-1:0]   xa,
  input logic [PA_W-1:0]   phys_addr,
  input logic [XA_N-1:0]   pin_is_xa,
  input logic [1:0]        win_active,
  input logic              cs1_use_xa,
  input logic              cs2_use_xa
);
  a_r2_pin_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_PIN) |=> pin_is_xa == $past(reg_wdata[XA_N-1:0]));

  a_r2_pin_read_top: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_PIN) |-> reg_rdata[7:6] == 2'b00);

  a_r3_cs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_SIZE) |=>
      (cs2_use_xa == $past(reg_wdata[7]) && cs1_use_xa == $past(reg_wdata[6])));

  a_r3_size_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_SIZE) |-> reg_rdata[3:2] == 2'b00);

  a_r8_one_window: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_active));

  a_r9_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (win_active == 2'b00) |->
      (xa[XA_N-1:OVL] == '0 && xa[OVL-1:0] == cpu_addr[CPU_AW-1:XA_LO]));

  a_r10_offset: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[PA_W-1:XA_LO] == xa);

  a_r11_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[2:1] == 2'b11) |-> reg_rdata == '0);
endmodule

bind bank_window_mapper bwm_checker u_chk (.*);

// File: tb/tb_bank_window_mapper.sv
`timescale 1ns/1ps
module tb_bank_window_mapper;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic [15:0] cpu_addr = 0;
  logic [5:0]  xa;
  logic [18:0] phys_addr;
  logic [5:0]  pin_is_xa;
  logic [1:0]  win_active;
  logic        cs1_use_xa, cs2_use_xa;

  int checks = 0;
  int errors = 0;
  int m_pin = 0, m_sz = 0;
  int m_base[2] = '{0, 0};
  int m_bank[2] = '{0, 0};

  always #4 clk = ~clk;

  bank_window_mapper dut (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_rdata(input int a);
    case (a)
      0: return m_pin;
      1: return m_sz & 'hF3;
      2: return m_base[0];
      3: return m_bank[0];
      4: return m_base[1];
      5: return m_bank[1];
      default: return 0;
    endcase
  endfunction

  task automatic model(input int cpu, output int xa_e, output int act_e, output string tag);
    int hv[2];
    int xw[2];
    int cd[2];
    for (int w = 0; w < 2; w++) begin
      int c, st, sp, lo;
      c  = (w == 0) ? (m_sz & 3) : ((m_sz >> 4) & 3);
      cd[w] = c;
      st = (c == 3) ? 'h4000 : m_base[w] * 256;
      sp = (c == 1) ? 'h2000 : (c == 2) ? 'h4000 : 'h8000;
      hv[w] = (c != 0) && cpu >= st && cpu < st + sp;
      lo = (c == 1) ? 13 : 14;
      xw[w] = 0;
      for (int l = 13; l <= 18; l++) begin
        int b;
        b = (l >= lo) ? ((m_bank[w] >> (l - lo)) & 1) : ((cpu >> l) & 1);
        xw[w] |= b << (l - 13);
      end
    end
    if (hv[0]) begin
      act_e = 1; xa_e = xw[0];
      tag = hv[1] ? "R8" : (cd[0] == 1) ? "R5" : (cd[0] == 2) ? "R6" : "R7";
    end else if (hv[1]) begin
      act_e = 2; xa_e = xw[1];
      tag = (cd[1] == 1) ? "R5" : (cd[1] == 2) ? "R6" : "R7";
    end else begin
      act_e = 0; xa_e = (cpu >> 13) & 7; tag = "R9";
    end
  endtask

  task automatic cyc(input bit wr, input int a, input int d, input int cpu, input string ovr);
    int xe, ae;
    string t;
    @(negedge clk);
    reg_wr = wr; reg_addr = 3'(a); reg_wdata = 8'(d); cpu_addr = 16'(cpu);
    #1;
    model(cpu, xe, ae, t);
    chk(ovr != "" ? ovr : t, "xa", int'(xa), xe);
    chk(ovr != "" ? ovr : "R4", "win_active", int'(win_active), ae);
    chk(ovr != "" ? ovr : "R10", "phys_addr", int'(phys_addr), (xe << 13) | (cpu & 'h1FFF));
    chk(ovr != "" ? ovr : (a == 0) ? "R2" : (a == 1) ? "R3" : (a >= 6) ? "R11" : "R4",
        "reg_rdata", int'(reg_rdata), exp_rdata(a));
    chk(ovr != "" ? ovr : "R2", "pin_is_xa", int'(pin_is_xa), m_pin);
    chk(ovr != "" ? ovr : "R3", "cs", int'({cs2_use_xa, cs1_use_xa}), (m_sz >> 6) & 3);
    @(posedge clk);
    if (wr) begin
      case (a)
        0: m_pin = d & 'h3F;
        1: m_sz = d & 'hF3;
        2: m_base[0] = d & 'hFF;
        3: m_bank[0] = d & 'h3F;
        4: m_base[1] = d & 'hFF;
        5: m_bank[1] = d & 'h3F;
        default: ;
      endcase
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1: reset state of every register and of the address path
    for (int a = 0; a < 8; a++) cyc(0, a, 0, 'hE000 + a * 'h123, "R1");

    // R2 / R3: register layouts, unused bits read zero
    cyc(1, 0, 'hFF, 0, "");
    cyc(0, 0, 0, 0, "");
    cyc(1, 1, 'hFF, 0, "");
    cyc(0, 1, 0, 0, "");
    cyc(1, 1, 'h40, 0, "");
    cyc(1, 0, 'h15, 0, "");
    cyc(0, 0, 0, 0, "");

    // Window registers: R4 bank upper bits read zero
    cyc(1, 2, 'h20, 0, "");
    cyc(1, 3, 'hEA, 0, "");
    cyc(1, 4, 'h30, 0, "");
    cyc(1, 5, 'h15, 0, "");
    for (int a = 2; a < 6; a++) cyc(0, a, 0, 0, "");

    // R11: writes to unmapped addresses change nothing
    cyc(1, 6, 'hFF, 0, "");
    cyc(1, 7, 'hFF, 0, "");
    for (int a = 0; a < 8; a++) cyc(0, a, 0, 0, "");

    // R4..R10: every pair of size codes over the whole CPU address space
    for (int c1 = 0; c1 < 4; c1++) begin
      for (int c2 = 0; c2 < 4; c2++) begin
        cyc(1, 1, (c2 << 4) | c1 | ((c1 ^ c2) << 6), 0, "");
        for (int cpu = 0; cpu < 'h10000; cpu += 'h0700) cyc(0, (cpu >> 8) & 7, 0, cpu, "");
        cyc(0, 1, 0, 'h1FFF, "");
        cyc(0, 1, 0, 'h2000, "");
        cyc(0, 1, 0, 'h3FFF, "");
        cyc(0, 1, 0, 'h4000, "");
        cyc(0, 1, 0, 'h4FFF, "");
        cyc(0, 1, 0, 'h5FFF, "");
        cyc(0, 1, 0, 'h6FFF, "");
        cyc(0, 1, 0, 'hBFFF, "");
        cyc(0, 1, 0, 'hC000, "");
        cyc(0, 1, 0, 'hFFFF, "");
      end
    end

    // R8: window 2 placed where window 1 also matches
    cyc(1, 4, 'h20, 0, "");
    cyc(1, 1, 'h11, 0, "");
    for (int cpu = 'h1F00; cpu < 'h4200; cpu += 'h100) cyc(0, 3, 0, cpu, "");
    cyc(1, 2, 'hF0, 0, "");
    cyc(1, 1, 'h12, 0, "");
    for (int cpu = 'hEF00; cpu <= 'hFF00; cpu += 'h100) cyc(0, 2, 0, cpu, "");

    finish_run();
  end
endmodule